// File: doc/BRIEF.md
# Address-Match Breakpoint Trigger Unit

This unit holds a small bank of breakpoint triggers for a 64-bit core that runs only at machine privilege. Software picks a trigger through a select register, then programs that trigger's control word and its 64-bit compare address. Each trigger can be armed for instruction fetch, data load and data store on its own, and each of these needs the machine-mode enable bit as well.

The core presents the address of every fetch, load and store in flight on three check ports. When an armed trigger's address equals the presented address, the unit raises a breakpoint request combinationally, in the same cycle. The request carries the breakpoint exception cause and the index of the lowest-numbered trigger that hit. A store that hits a store trigger has its write-enable withheld, so memory is never updated. Control values that the unit cannot hold read back changed, and an absent trigger index never reads back from the select register. Software uses both behaviours to find out what the unit supports.

Top module: `bpt_unit`

## Requirements
- R1: After reset the select register reads 0x8000_0000_0000_0000 (trigger 0). A write whose bit 63 is set and whose low 63 bits are less than NUM_TRIG is stored and reads back exactly.
- R2: A select write that names an absent trigger, or that has bit 63 clear, is ignored. The register keeps its previous value.
- R3: The control register reads with bits 63:60 equal to 1 (address match). Only bit 6 (machine enable), bit 2 (execute), bit 1 (store) and bit 0 (load) are writable. Every other bit reads 0.
- R4: The address register of the selected trigger stores and reads back all 64 bits. Register codes on csr_sel are: 0 select, 1 control, 2 address, 3 reads zero.
- R5: After reset every trigger has all enables clear and address zero, so no access raises a request.
- R6: A trigger armed with machine and execute enables fires on a fetch to its address. It does not fire on a load to that address.
- R7: A trigger armed with machine and load enables fires on a load to its address. It does not fire on a store to that address, and that store still commits.
- R8: A store that hits a trigger armed with machine and store enables raises a request and drives store_commit low in the same cycle.
- R9: bp_req comes with bp_cause equal to 3 and with bp_index naming the lowest-index trigger that hit. bp_cause is 0 when there is no request.
- R10: Two triggers armed at the same time work independently. Programming trigger 1 does not disarm trigger 0.
- R11: An access enable without the machine enable (bit 6) never fires.
- R12: Matching is exact equality on all 64 address bits. An address that differs in any bit does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the register port |
| csr_sel | input | 2 | Register code: 0 select, 1 control, 2 address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Combinational read data for csr_sel |
| fetch_valid | input | 1 | Fetch address is present |
| fetch_addr | input | 64 | Fetch address |
| load_valid | input | 1 | Load address is present |
| load_addr | input | 64 | Load address |
| store_valid | input | 1 | Store address is present |
| store_addr | input | 64 | Store address |
| bp_req | output | 1 | Breakpoint exception request |
| bp_cause | output | 4 | Exception cause, 3 while bp_req is high |
| bp_index | output | IDX_W | Lowest trigger index that hit |
| store_commit | output | 1 | The store may update memory |

## Verification
A register write takes effect at the clock edge that samples csr_we. Its readback is therefore due one cycle later, and the bench reads back only after that edge. Read data and all breakpoint outputs are combinational on the current register contents and the check-port inputs. Each check drives its inputs just after a falling edge and samples about one nanosecond later, before the next rising edge. This way no result depends on the order of processes at a clock edge.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    localparam int XLEN = 64;

    localparam logic [1:0] REG_SELECT  = 2'd0;
    localparam logic [1:0] REG_CONTROL = 2'd1;
    localparam logic [1:0] REG_ADDRESS = 2'd2;

    localparam int BIT_LOAD  = 0;
    localparam int BIT_STORE = 1;
    localparam int BIT_EXEC  = 2;
    localparam int BIT_MACH  = 6;

    localparam logic [3:0] KIND_ADDR_MATCH = 4'd1;
    localparam logic [3:0] CAUSE_BREAK     = 4'd3;

    typedef struct packed {
        logic            mach;
        logic            exec;
        logic            store;
        logic            load;
        logic [XLEN-1:0] addr;
    } trig_cfg_t;

    function automatic logic [XLEN-1:0] control_image(input trig_cfg_t c);
        logic [XLEN-1:0] w;
        w = '0;
        w[XLEN-1 -: 4] = KIND_ADDR_MATCH;
        w[BIT_MACH]    = c.mach;
        w[BIT_EXEC]    = c.exec;
        w[BIT_STORE]   = c.store;
        w[BIT_LOAD]    = c.load;
        return w;
    endfunction
endpackage

// File: rtl/bpt_regs.sv
module bpt_regs
    import bpt_pkg::*;
#(
    parameter int NUM_TRIG = 2,
    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [1:0]                    sel,
    input  logic [XLEN-1:0]               wdata,
    output logic [XLEN-1:0]               rdata,
    output trig_cfg_t [NUM_TRIG-1:0]      cfg
);
    logic [XLEN-1:0] select_q;
    logic [IDX_W-1:0] cur;
    logic             sel_ok;

    assign cur    = select_q[IDX_W-1:0];
    assign sel_ok = wdata[XLEN-1] &&
                    (wdata[XLEN-2:0] < (XLEN-1)'(NUM_TRIG));

    always_ff @(posedge clk) begin
        if (rst)
            select_q <= {1'b1, {(XLEN-1){1'b0}}};
        else if (we && sel == REG_SELECT && sel_ok)
            select_q <= wdata;
    end

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (we && cur == IDX_W'(i)) begin
                if (sel == REG_CONTROL) begin
                    cfg[i].mach  <= wdata[BIT_MACH];
                    cfg[i].exec  <= wdata[BIT_EXEC];
                    cfg[i].store <= wdata[BIT_STORE];
                    cfg[i].load  <= wdata[BIT_LOAD];
                end else if (sel == REG_ADDRESS) begin
                    cfg[i].addr <= wdata;
                end
            end
        end
    end

    always_comb begin
        case (sel)
            REG_SELECT:  rdata = select_q;
            REG_CONTROL: rdata = control_image(cfg[cur]);
            REG_ADDRESS: rdata = cfg[cur].addr;
            default:     rdata = '0;
        endcase
    end

    assert_select_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_SELECT && !sel_ok) |=> $stable(select_q));
    assert_select_take_R1: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_SELECT && sel_ok) |=> select_q == $past(wdata));
    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == '0));
endmodule

// File: rtl/bpt_match.sv
module bpt_match
    import bpt_pkg::*;
#(
    parameter int NUM_TRIG = 2
) (
    input  trig_cfg_t [NUM_TRIG-1:0] cfg,
    input  logic                     fetch_valid,
    input  logic [XLEN-1:0]          fetch_addr,
    input  logic                     load_valid,
    input  logic [XLEN-1:0]          load_addr,
    input  logic                     store_valid,
    input  logic [XLEN-1:0]          store_addr,
    output logic [NUM_TRIG-1:0]      fetch_hit,
    output logic [NUM_TRIG-1:0]      load_hit,
    output logic [NUM_TRIG-1:0]      store_hit
);
    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
        assign fetch_hit[i] = fetch_valid && cfg[i].mach && cfg[i].exec
                              && (fetch_addr == cfg[i].addr);
        assign load_hit[i]  = load_valid && cfg[i].mach && cfg[i].load
                              && (load_addr == cfg[i].addr);
        assign store_hit[i] = store_valid && cfg[i].mach && cfg[i].store
                              && (store_addr == cfg[i].addr);
    end
endmodule

// File: rtl/bpt_prio.sv
module bpt_prio #(
    parameter int NUM_TRIG = 2,
    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic [NUM_TRIG-1:0] hits,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bpt_unit.sv
module bpt_unit
    import bpt_pkg::*;
#(
    parameter int NUM_TRIG = 2,
    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [1:0]       csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    input  logic             fetch_valid,
    input  logic [XLEN-1:0]  fetch_addr,
    input  logic             load_valid,
    input  logic [XLEN-1:0]  load_addr,
    input  logic             store_valid,
    input  logic [XLEN-1:0]  store_addr,
    output logic             bp_req,
    output logic [3:0]       bp_cause,
    output logic [IDX_W-1:0] bp_index,
    output logic             store_commit
);
    trig_cfg_t [NUM_TRIG-1:0] cfg;
    logic [NUM_TRIG-1:0]      f_hit, l_hit, s_hit;

    bpt_regs #(.NUM_TRIG(NUM_TRIG)) u_regs (
        .clk(clk), .rst(rst), .we(csr_we), .sel(csr_sel),
        .wdata(csr_wdata), .rdata(csr_rdata), .cfg(cfg)
    );

    bpt_match #(.NUM_TRIG(NUM_TRIG)) u_match (
        .cfg(cfg),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .load_valid(load_valid),   .load_addr(load_addr),
        .store_valid(store_valid), .store_addr(store_addr),
        .fetch_hit(f_hit), .load_hit(l_hit), .store_hit(s_hit)
    );

    bpt_prio #(.NUM_TRIG(NUM_TRIG)) u_prio (
        .hits(f_hit | l_hit | s_hit), .found(bp_req), .idx(bp_index)
    );

    assign bp_cause     = bp_req ? CAUSE_BREAK : 4'd0;
    assign store_commit = store_valid && !(|s_hit);

    assert_store_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (|s_hit) |-> (!store_commit && bp_req));
    assert_cause_code_R9: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> bp_cause == CAUSE_BREAK);
    assert_lowest_index_R9: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> (((f_hit | l_hit | s_hit) >> bp_index) & 1) == 1
                   && (((f_hit | l_hit | s_hit) & ((NUM_TRIG'(1) << bp_index) - 1)) == 0));
    assert_req_has_hit_R12: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> (|(f_hit | l_hit | s_hit)));
endmodule

// File: tb/bpt_unit_test.sv
module bpt_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] MSB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] KIND = 64'h1000_0000_0000_0000;
    localparam logic [63:0] A = 64'h8000_0000_0000_1000;
    localparam logic [63:0] B = 64'h0000_0000_2000_0040;

    logic        clk = 0, rst = 1, csr_we = 0;
    logic [1:0]  csr_sel = 0;
    logic [63:0] csr_wdata = 0, csr_rdata;
    logic        fetch_valid = 0, load_valid = 0, store_valid = 0;
    logic [63:0] fetch_addr = 0, load_addr = 0, store_addr = 0;
    logic        bp_req, store_commit;
    logic [3:0]  bp_cause;
    logic [0:0]  bp_index;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpt_unit #(.NUM_TRIG(2)) uut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .load_valid(load_valid), .load_addr(load_addr),
        .store_valid(store_valid), .store_addr(store_addr),
        .bp_req(bp_req), .bp_cause(bp_cause), .bp_index(bp_index),
        .store_commit(store_commit)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1; csr_sel = s; csr_wdata = d;
        @(negedge clk);
        csr_we = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        csr_sel = s;
        #1 d = csr_rdata;
    endtask

    // kind: 0 fetch, 1 load, 2 store
    task automatic access(input int kind, input logic [63:0] a);
        @(negedge clk);
        fetch_valid = (kind == 0); fetch_addr = a;
        load_valid  = (kind == 1); load_addr  = a;
        store_valid = (kind == 2); store_addr = a;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        fetch_valid = 0; load_valid = 0; store_valid = 0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(0, v); check("R1 reset select", v, MSB);
        rd(1, v); check("R5 reset control", v, KIND);
        rd(2, v); check("R5 reset address", v, 64'h0);
        access(0, 64'h0); check("R5 no fire after reset", bp_req, 0);
        check("R9 cause idle", bp_cause, 0);
        idle();
    endtask

    task automatic t_select();
        logic [63:0] v;
        wr(0, MSB + 1); rd(0, v); check("R1 select trigger1", v, MSB + 1);
        wr(0, MSB + 2); rd(0, v); check("R2 absent trigger ignored", v, MSB + 1);
        wr(0, 64'd0);   rd(0, v); check("R2 msb clear ignored", v, MSB + 1);
        wr(0, MSB);     rd(0, v); check("R1 select trigger0", v, MSB);
    endtask

    task automatic t_regs();
        logic [63:0] v;
        wr(1, 64'hFFFF_FFFF_FFFF_FFFF); rd(1, v);
        check("R3 only legal bits kept", v, KIND | 64'h47);
        wr(1, 64'h44); rd(1, v); check("R3 exec readback", v, KIND | 64'h44);
        wr(2, 64'hDEAD_BEEF_0123_4567); rd(2, v);
        check("R4 address readback", v, 64'hDEAD_BEEF_0123_4567);
        wr(2, A); rd(2, v); check("R4 address rewrite", v, A);
    endtask

    task automatic t_exec();
        wr(0, MSB); wr(2, A); wr(1, 64'h44);
        access(0, A);
        check("R6 fetch fires", bp_req, 1);
        check("R9 cause", bp_cause, 3);
        check("R9 index", bp_index, 0);
        access(1, A); check("R6 load on exec trigger", bp_req, 0);
        access(0, A ^ 64'h4); check("R12 near address", bp_req, 0);
        access(0, A ^ MSB); check("R12 top bit differs", bp_req, 0);
        idle();
    endtask

    task automatic t_load();
        wr(0, MSB); wr(1, 64'h41);
        access(1, A); check("R7 load fires", bp_req, 1);
        access(2, A); check("R7 store on load trigger", bp_req, 0);
        check("R7 store commits", store_commit, 1);
        idle();
    endtask

    task automatic t_store();
        wr(0, MSB); wr(1, 64'h42);
        access(2, A);
        check("R8 store fires", bp_req, 1);
        check("R8 store suppressed", store_commit, 0);
        access(2, A + 8); check("R8 other store commits", store_commit, 1);
        idle();
    endtask

    task automatic t_nomach();
        wr(0, MSB); wr(1, 64'h07);
        access(0, A); check("R11 fetch no mach", bp_req, 0);
        access(1, A); check("R11 load no mach", bp_req, 0);
        access(2, A); check("R11 store no mach", bp_req, 0);
        idle();
    endtask

    task automatic t_two();
        wr(0, MSB); wr(1, 64'h42);
        wr(0, MSB + 1); wr(2, B); wr(1, 64'h41);
        access(1, B);
        check("R10 trigger1 fires", bp_req, 1);
        check("R10 trigger1 index", bp_index, 1);
        access(2, A);
        check("R10 trigger0 still armed", bp_req, 1);
        check("R10 trigger0 index", bp_index, 0);
        check("R10 store suppressed", store_commit, 0);
        wr(2, A); wr(1, 64'h42);
        access(2, A); check("R9 lowest index wins", bp_index, 0);
        check("R9 single request", bp_req, 1);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_select();
        t_regs();
        t_exec();
        t_load();
        t_store();
        t_nomach();
        t_two();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule